// File: doc/BRIEF.md
# Microprogram Sequencer with Single-Level Subroutine Save

This block produces the control-store address for a microcoded processor. A control address register drives the address of the next microinstruction. Each clock, the register takes one of several values: its own value plus one, a branch target from the current microinstruction, an entry point computed from the instruction opcode, or an address kept in a save register. The microinstruction chooses among them with a three-bit next-address code. Conditional branches test one status bit, picked by a select field.

A single save register allows one level of microsubroutine. A call stores the address after the caller in that register and jumps to the target on the same edge. A return jumps back to the stored address. A second call before a return replaces the stored address.

A microinstruction that ends an execute routine sets an exit flag. The exit overrides the next-address code. The sequencer then goes either to the interrupt entry, if an interrupt is pending, or to the fetch routine. Reset puts the register on the fetch routine.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, `car` reads 0x00 and `sbr` reads 0x00 at once, without a clock edge. After `rst_n` rises, `car` holds 0x00 through the first two rising edges and first changes on the third.
- R2: Code 000 (increment) loads `car` with `car`+1, modulo 2^ADDR_W, so 0xFF becomes 0x00. The unused codes 110 and 111 act in the same way.
- R3: Code 001 (branch if set) loads `br_addr` when `status[cond_sel]` is 1. Otherwise it increments.
- R4: Code 010 (branch if clear) loads `br_addr` when `status[cond_sel]` is 0. Otherwise it increments.
- R5: Code 011 (map) loads `car` with 0x40 + 4×`opcode`.
- R6: Code 100 (call) loads `sbr` with `car`+1 and `car` with `br_addr` on the same edge. A later call overwrites `sbr`.
- R7: Code 101 (return) loads `car` with `sbr` and leaves `sbr` unchanged.
- R8: `sbr` changes only on an accepted call. It is held under every other code and on an exit.
- R9: With `exec_done` high, the code field is ignored. `car` becomes 0xF0 if `irq_pending` is 1, and 0x00 otherwise. `irq_take` equals `exec_done` AND `irq_pending` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| nxt_sel | input | 3 | Next-address code from the microinstruction |
| cond_sel | input | 3 | Index of the status bit tested by branches |
| br_addr | input | 8 | Branch or call target |
| status | input | 8 | Status bits for conditional branches |
| opcode | input | 4 | Instruction opcode used by the map code |
| exec_done | input | 1 | Exit marker: end of execute routine |
| irq_pending | input | 1 | Interrupt request awaiting service |
| car | output | 8 | Control address register |
| sbr | output | 8 | Subroutine save register |
| irq_take | output | 1 | Exit in this cycle goes to the interrupt entry |

## Verification
An exit and a next-address code can arrive in the same microinstruction. The main case is an exit that carries a call code, which could write the save register while the exit steers the control address elsewhere. The bench drives an exit together with a call to a different target and with an increment code, both with and without a pending interrupt. It expects the control address to land on the fetch or interrupt entry and the save register to keep the address stored by the earlier call. A return right after such a collision confirms that the saved address survived.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    NA_INC  = 3'b000,
    NA_BRT  = 3'b001,
    NA_BRF  = 3'b010,
    NA_MAP  = 3'b011,
    NA_CALL = 3'b100,
    NA_RET  = 3'b101
  } na_sel_e;
endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  // Assert asynchronously; release only after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter  int NCOND  = 8,
  localparam int CSEL_W = $clog2(NCOND)
) (
  input  logic [NCOND-1:0]  status,
  input  logic [CSEL_W-1:0] cond_sel,
  output logic              cond
);
  always_comb begin
    cond = 1'b0;
    for (int i = 0; i < NCOND; i++) begin
      if (CSEL_W'(i) == cond_sel) cond = status[i];
    end
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OPC_W      = 4,
  parameter int MAP_SHIFT  = 2,
  parameter logic [ADDR_W-1:0] FETCH_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] IRQ_ADDR   = 'hF0,
  parameter logic [ADDR_W-1:0] MAP_BASE   = 'h40
) (
  input  logic [ADDR_W-1:0] car_q,
  input  logic [ADDR_W-1:0] sbr_q,
  input  logic [2:0]        nxt_sel,
  input  logic              cond,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              exec_done,
  input  logic              irq_pending,
  output logic [ADDR_W-1:0] car_d,
  output logic              sbr_load,
  output logic [ADDR_W-1:0] sbr_d,
  output logic              irq_take
);
  localparam int OFS_W = OPC_W + MAP_SHIFT;

  logic [ADDR_W-1:0] car_inc;
  logic [ADDR_W-1:0] map_addr;
  logic [OFS_W-1:0]  map_ofs;

  assign car_inc  = car_q + 1'b1;
  assign map_ofs  = {opcode, {MAP_SHIFT{1'b0}}};
  assign map_addr = MAP_BASE + ADDR_W'(map_ofs);
  assign irq_take = exec_done & irq_pending;
  assign sbr_d    = car_inc;

  always_comb begin
    car_d    = car_inc;
    sbr_load = 1'b0;
    if (exec_done) begin
      car_d = irq_pending ? IRQ_ADDR : FETCH_ADDR;
    end else begin
      case (na_sel_e'(nxt_sel))
        NA_BRT:  car_d = cond  ? br_addr : car_inc;
        NA_BRF:  car_d = !cond ? br_addr : car_inc;
        NA_MAP:  car_d = map_addr;
        NA_CALL: begin
          car_d    = br_addr;
          sbr_load = 1'b1;
        end
        NA_RET:  car_d = sbr_q;
        default: car_d = car_inc;
      endcase
    end
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter  int ADDR_W    = 8,
  parameter  int OPC_W     = 4,
  parameter  int NCOND     = 8,
  parameter  int MAP_SHIFT = 2,
  parameter  logic [ADDR_W-1:0] FETCH_ADDR = 'h00,
  parameter  logic [ADDR_W-1:0] IRQ_ADDR   = 'hF0,
  parameter  logic [ADDR_W-1:0] MAP_BASE   = 'h40,
  localparam int CSEL_W = $clog2(NCOND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        nxt_sel,
  input  logic [CSEL_W-1:0] cond_sel,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [NCOND-1:0]  status,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              exec_done,
  input  logic              irq_pending,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] sbr,
  output logic              irq_take
);
  logic              rst_sync_n;
  logic              cond;
  logic [ADDR_W-1:0] car_q, car_d;
  logic [ADDR_W-1:0] sbr_q, sbr_d;
  logic              sbr_load;

  useq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  useq_cond_mux #(.NCOND(NCOND)) u_cond (
    .status(status), .cond_sel(cond_sel), .cond(cond)
  );

  useq_next_addr #(
    .ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_SHIFT(MAP_SHIFT),
    .FETCH_ADDR(FETCH_ADDR), .IRQ_ADDR(IRQ_ADDR), .MAP_BASE(MAP_BASE)
  ) u_next (
    .car_q(car_q), .sbr_q(sbr_q), .nxt_sel(nxt_sel), .cond(cond),
    .br_addr(br_addr), .opcode(opcode), .exec_done(exec_done),
    .irq_pending(irq_pending), .car_d(car_d), .sbr_load(sbr_load),
    .sbr_d(sbr_d), .irq_take(irq_take)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) car_q <= FETCH_ADDR;
    else             car_q <= car_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   sbr_q <= FETCH_ADDR;
    else if (sbr_load) sbr_q <= sbr_d;
  end

  assign car = car_q;
  assign sbr = sbr_q;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int ADDR_W = 8,
  parameter int NCOND  = 8,
  parameter int CSEL_W = 3,
  parameter logic [ADDR_W-1:0] FETCH_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] IRQ_ADDR   = 'hF0
) (
  input logic              clk,
  input logic              rst_q,
  input logic [2:0]        nxt_sel,
  input logic [CSEL_W-1:0] cond_sel,
  input logic [ADDR_W-1:0] br_addr,
  input logic [NCOND-1:0]  status,
  input logic              exec_done,
  input logic              irq_pending,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr,
  input logic              irq_take
);
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_q)
    (!exec_done && nxt_sel == 3'b000) |=> car == ADDR_W'($past(car) + 1'b1));

  a_r3_branch_set: assert property (@(posedge clk) disable iff (!rst_q)
    (!exec_done && nxt_sel == 3'b001 && status[cond_sel]) |=> car == $past(br_addr));

  a_r4_branch_clear: assert property (@(posedge clk) disable iff (!rst_q)
    (!exec_done && nxt_sel == 3'b010 && !status[cond_sel]) |=> car == $past(br_addr));

  a_r6_call: assert property (@(posedge clk) disable iff (!rst_q)
    (!exec_done && nxt_sel == 3'b100)
      |=> (car == $past(br_addr)) && (sbr == ADDR_W'($past(car) + 1'b1)));

  a_r7_return: assert property (@(posedge clk) disable iff (!rst_q)
    (!exec_done && nxt_sel == 3'b101) |=> car == $past(sbr));

  a_r8_sbr_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !(!exec_done && nxt_sel == 3'b100) |=> $stable(sbr));

  a_r9_exit_target: assert property (@(posedge clk) disable iff (!rst_q)
    exec_done |=> car == ($past(irq_pending) ? IRQ_ADDR : FETCH_ADDR));

  a_r9_take_flag: assert property (@(posedge clk) disable iff (!rst_q)
    irq_take |-> (exec_done && irq_pending));
endmodule

bind useq_sequencer useq_sequencer_chk #(
  .ADDR_W(ADDR_W), .NCOND(NCOND), .CSEL_W(CSEL_W),
  .FETCH_ADDR(FETCH_ADDR), .IRQ_ADDR(IRQ_ADDR)
) u_chk (
  .clk(clk), .rst_q(rst_sync_n), .nxt_sel(nxt_sel), .cond_sel(cond_sel),
  .br_addr(br_addr), .status(status), .exec_done(exec_done),
  .irq_pending(irq_pending), .car(car), .sbr(sbr), .irq_take(irq_take)
);

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] nxt_sel;
  logic [2:0] cond_sel;
  logic [7:0] br_addr;
  logic [7:0] status;
  logic [3:0] opcode;
  logic       exec_done;
  logic       irq_pending;
  logic [7:0] car;
  logic [7:0] sbr;
  logic       irq_take;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk(clk), .rst_n(rst_n), .nxt_sel(nxt_sel), .cond_sel(cond_sel),
    .br_addr(br_addr), .status(status), .opcode(opcode),
    .exec_done(exec_done), .irq_pending(irq_pending),
    .car(car), .sbr(sbr), .irq_take(irq_take)
  );

  typedef struct packed {
    logic [2:0] sel;
    logic [2:0] csel;
    logic [7:0] br;
    logic [7:0] st;
    logic [3:0] opc;
    logic       done;
    logic       irq;
    logic [7:0] e_car;
    logic [7:0] e_sbr;
    logic       e_take;
  } vec_t;

  localparam int NV = 20;
  // Chain starts at car=00, sbr=00.
  localparam vec_t VEC [NV] = '{
    '{3'd0, 3'd0, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 8'h01, 8'h00, 1'b0}, // R2
    '{3'd0, 3'd0, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 8'h02, 8'h00, 1'b0}, // R2
    '{3'd3, 3'd0, 8'h00, 8'h00, 4'h5, 1'b0, 1'b0, 8'h54, 8'h00, 1'b0}, // R5
    '{3'd1, 3'd3, 8'h30, 8'h08, 4'h0, 1'b0, 1'b0, 8'h30, 8'h00, 1'b0}, // R3 taken
    '{3'd1, 3'd3, 8'h10, 8'hF7, 4'h0, 1'b0, 1'b0, 8'h31, 8'h00, 1'b0}, // R3 not taken
    '{3'd2, 3'd1, 8'h60, 8'hFD, 4'h0, 1'b0, 1'b0, 8'h60, 8'h00, 1'b0}, // R4 taken
    '{3'd2, 3'd1, 8'h10, 8'h02, 4'h0, 1'b0, 1'b0, 8'h61, 8'h00, 1'b0}, // R4 not taken
    '{3'd4, 3'd0, 8'h80, 8'h00, 4'h0, 1'b0, 1'b0, 8'h80, 8'h62, 1'b0}, // R6 call
    '{3'd0, 3'd0, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 8'h81, 8'h62, 1'b0}, // R8 hold
    '{3'd4, 3'd0, 8'h90, 8'h00, 4'h0, 1'b0, 1'b0, 8'h90, 8'h82, 1'b0}, // R6 overwrite
    '{3'd5, 3'd0, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 8'h82, 8'h82, 1'b0}, // R7 return
    '{3'd4, 3'd0, 8'h77, 8'h00, 4'h0, 1'b1, 1'b0, 8'h00, 8'h82, 1'b0}, // R9 exit beats call
    '{3'd6, 3'd0, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 8'h01, 8'h82, 1'b0}, // R2 code 110
    '{3'd1, 3'd7, 8'h20, 8'h80, 4'h0, 1'b0, 1'b0, 8'h20, 8'h82, 1'b0}, // R3 top bit
    '{3'd4, 3'd0, 8'h55, 8'h00, 4'h0, 1'b1, 1'b1, 8'hF0, 8'h82, 1'b1}, // R9 irq, call ignored
    '{3'd5, 3'd0, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 8'h82, 8'h82, 1'b0}, // R8 sbr survived
    '{3'd3, 3'd0, 8'h00, 8'h00, 4'hF, 1'b0, 1'b0, 8'h7C, 8'h82, 1'b0}, // R5 max opcode
    '{3'd1, 3'd0, 8'hFF, 8'h01, 4'h0, 1'b0, 1'b0, 8'hFF, 8'h82, 1'b0}, // R3 to top
    '{3'd7, 3'd0, 8'h00, 8'h00, 4'h0, 1'b0, 1'b0, 8'h00, 8'h82, 1'b0}, // R2 wrap, code 111
    '{3'd0, 3'd0, 8'h00, 8'h00, 4'h0, 1'b1, 1'b1, 8'hF0, 8'h82, 1'b1}  // R9 irq
  };
  localparam string TAG [NV] = '{"R2","R2","R5","R3","R3","R4","R4","R6","R8","R6",
                                 "R7","R9","R2","R3","R9","R8","R5","R3","R2","R9"};

  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    nxt_sel = 3'd0; cond_sel = 3'd0; br_addr = 8'h00; status = 8'h00;
    opcode = 4'h0; exec_done = 1'b0; irq_pending = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "car in reset", car, 8'h00);
    check("R1", "sbr in reset", sbr, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R1", "car held after 2 edges", car, 8'h00);
    @(posedge clk);
    #1 check("R1", "car first step", car, 8'h01);
    // Re-align chain to 00 via exit without interrupt (R9).
    @(negedge clk);
    exec_done = 1'b1;
    @(posedge clk);
    #1 check("R9", "exit to fetch", car, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      nxt_sel = VEC[i].sel; cond_sel = VEC[i].csel; br_addr = VEC[i].br;
      status = VEC[i].st; opcode = VEC[i].opc; exec_done = VEC[i].done;
      irq_pending = VEC[i].irq;
      #1 check(TAG[i], "irq_take", {7'd0, irq_take}, {7'd0, VEC[i].e_take});
      @(posedge clk);
      #1;
      check(TAG[i], "car", car, VEC[i].e_car);
      check(TAG[i], "sbr", sbr, VEC[i].e_sbr);
    end

    // R9: pending interrupt alone, without exit, has no effect.
    @(negedge clk);
    drive_idle();
    irq_pending = 1'b1;
    #1 check("R9", "no take without exit", {7'd0, irq_take}, 8'h00);
    @(posedge clk);
    #1 check("R9", "irq without exit increments", car, 8'hF1);

    // R1: asynchronous reset in mid-run, no edge needed.
    @(negedge clk);
    drive_idle();
    #2 rst_n = 1'b0;
    #1;
    check("R1", "async car clear", car, 8'h00);
    check("R1", "async sbr clear", sbr, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
    finish_run();
  end
endmodule